// File: doc/BRIEF.md
# Secondary Slot Expander Pair

This block extends the memory slot system of an 8-bit computer that has a 16-bit memory bus. Each expander sits behind one primary slot and fans it out into four subslots. A control register holds two bits for each 16 KB page. It sits at the very top of the memory map, at address FFFFh, and it is only reachable while the primary slot of its own expander is selected. Each expander therefore keeps its own subslot configuration.

One FFFFh comparator is shared by every expander instance in the block, for example one expander on primary slot 0 and another on primary slot 3. Reading FFFFh returns the complement of the register. Software uses this to detect that a slot is expanded. For each expander the block also outputs the two-bit subslot choice of the current page. These two bits can serve as the upper address bits of a 256 KB flash device, which splits it into four 64 KB windows. An optional broadcast input lets a write to FFFFh update every expander at once.

Top module: `subslot_pair`

## Requirements
- R1: Reset clears every control register to 00h, so every page of every expander maps to subslot 0.
- R2: A write to FFFFh while an expander's `slot_sel_n` bit is low stores `wdata` in that expander's register. The register of any other expander is unchanged.
- R3: While `bcast_wr` is low, a write to FFFFh has no effect on an expander whose `slot_sel_n` bit is high.
- R4: An access to FFFFh (read or write) never drives any subslot select low. A read at FFFFh with a selected expander raises `rdata_oe` and returns the bitwise complement of that expander's register. When several expanders are selected, the lowest index wins.
- R5: The page is given by addr[15:14]. Page p uses register bits [2p+1:2p], so bits 1:0 serve 0000h–3FFFh and bits 7:6 serve C000h–FFFEh.
- R6: The field value k of the current page drives `sub_sel_n[4*i+k]` low for expander i. This happens only while that expander is selected and `rd` or `wr` is high. At most one of the four selects of an expander is low at any time.
- R7: `flash_page[2*i+1:2*i]` always equals expander i's field for the current page. It forms the upper two address bits of a 256 KB flash.
- R8: When `bcast_wr` is high, a write to FFFFh loads `wdata` into every expander, whatever the state of `slot_sel_n`.
- R9: `rdata_oe` is low and `rdata` is 00h whenever the access is not a read of FFFFh by a selected expander.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Memory address |
| wdata | input | 8 | Write data |
| rd | input | 1 | Memory read strobe, active high |
| wr | input | 1 | Memory write strobe, active high |
| slot_sel_n | input | N_EXP | Primary slot select of each expander, active low |
| bcast_wr | input | 1 | Broadcast mode: writes to FFFFh ignore the slot select |
| rdata | output | 8 | Complemented register readback |
| rdata_oe | output | 1 | Readback is being driven |
| sub_sel_n | output | 4*N_EXP | Subslot selects, active low, four per expander |
| flash_page | output | 2*N_EXP | Current page's subslot field per expander |

## Verification
The hardest situation to bring about is one where two expanders hold different values at the same moment. Only then can a leak of a write into the wrong expander show up. The stimulus writes mirror-image patterns into the two expanders with alternating selects. It then reads both registers back and sweeps every page on both expanders, so that any cross-write or swapped field appears as a wrong select. After that, a deselected write and a broadcast write are each followed at once by readback.

// File: rtl/subslot_pair.sv
module subslot_pair #(
  parameter int N_EXP   = 2,
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int N_SUB   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic                   rd,
  input  logic                   wr,
  input  logic [N_EXP-1:0]       slot_sel_n,
  input  logic                   bcast_wr,
  output logic [DW-1:0]          rdata,
  output logic                   rdata_oe,
  output logic [N_SUB*N_EXP-1:0] sub_sel_n,
  output logic [2*N_EXP-1:0]     flash_page
);
  localparam int FW = $clog2(N_SUB);

  logic            top_hit;
  logic [FW-1:0]   page;
  logic [DW-1:0]   ctl [N_EXP];

  assign top_hit = &addr;
  assign page    = addr[AW-1 -: FW];

  for (genvar i = 0; i < N_EXP; i++) begin : g_exp
    logic [FW-1:0] field;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        ctl[i] <= '0;
      else if (wr && top_hit && (!slot_sel_n[i] || bcast_wr))
        ctl[i] <= wdata;

    assign field = ctl[i][FW*page +: FW];
    assign flash_page[2*i +: 2] = field;

    for (genvar k = 0; k < N_SUB; k++) begin : g_sub
      assign sub_sel_n[N_SUB*i + k] =
        !(!slot_sel_n[i] && (rd || wr) && !top_hit && field == FW'(k));
    end
  end

  always_comb begin
    rdata    = '0;
    rdata_oe = 1'b0;
    for (int i = N_EXP - 1; i >= 0; i--)
      if (rd && top_hit && !slot_sel_n[i]) begin
        rdata    = ~ctl[i];
        rdata_oe = 1'b1;
      end
  end
endmodule

// File: rtl/subslot_pair_chk.sv
module subslot_pair_chk #(
  parameter int N_EXP = 2,
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int N_SUB = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [AW-1:0]          addr,
  input logic [DW-1:0]          wdata,
  input logic                   rd,
  input logic                   wr,
  input logic [N_EXP-1:0]       slot_sel_n,
  input logic [DW-1:0]          rdata,
  input logic                   rdata_oe,
  input logic [N_SUB*N_EXP-1:0] sub_sel_n
);
  for (genvar i = 0; i < N_EXP; i++) begin : g_chk
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sub_sel_n[N_SUB*i +: N_SUB]));
    p_desel_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      slot_sel_n[i] |-> &sub_sel_n[N_SUB*i +: N_SUB]);
  end

  p_reg_hidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || wr) && &addr) |-> &sub_sel_n);

  p_oe_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (!rdata_oe && rdata == '0));

  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && &addr && !slot_sel_n[0]) |=>
      (!(rd && &addr && !slot_sel_n[0]) || rdata == ~$past(wdata)));
endmodule

bind subslot_pair subslot_pair_chk #(.N_EXP(N_EXP), .AW(AW), .DW(DW), .N_SUB(N_SUB)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
  .slot_sel_n(slot_sel_n), .rdata(rdata), .rdata_oe(rdata_oe), .sub_sel_n(sub_sel_n)
);

// File: tb/subslot_pair_bench.sv
module subslot_pair_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 0, wr = 0, bcast_wr = 0;
  logic [1:0]  slot_sel_n = 2'b11;
  logic [7:0]  rdata;
  logic        rdata_oe;
  logic [7:0]  sub_sel_n;
  logic [3:0]  flash_page;

  int errors = 0, checks = 0;
  bit done = 0;

  subslot_pair u_subslot_pair (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
    .slot_sel_n(slot_sel_n), .bcast_wr(bcast_wr), .rdata(rdata),
    .rdata_oe(rdata_oe), .sub_sel_n(sub_sel_n), .flash_page(flash_page)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {seln, rd, wr, bcast, addr, wdata, exp sub_sel_n, exp flash, exp oe, exp rdata}
  localparam logic [49:0] VEC [NV] = '{
    {2'b10,1'b1,1'b0,1'b0,16'h0000,8'h00,8'hFE,4'h0,1'b0,8'h00}, // R1 exp0 page0 sub0
    {2'b10,1'b0,1'b1,1'b0,16'hFFFF,8'hE4,8'hFF,4'h0,1'b0,8'h00}, // R2 write exp0
    {2'b01,1'b0,1'b1,1'b0,16'hFFFF,8'h1B,8'hFF,4'h3,1'b0,8'h00}, // R2 write exp1
    {2'b10,1'b1,1'b0,1'b0,16'hFFFF,8'h00,8'hFF,4'h3,1'b1,8'h1B}, // R4 readback exp0
    {2'b01,1'b1,1'b0,1'b0,16'hFFFF,8'h00,8'hFF,4'h3,1'b1,8'hE4}, // R4 readback exp1
    {2'b10,1'b1,1'b0,1'b0,16'h4000,8'h00,8'hFD,4'h9,1'b0,8'h00}, // R5 page1
    {2'b01,1'b0,1'b1,1'b0,16'h8000,8'h00,8'hDF,4'h6,1'b0,8'h00}, // R5 page2 write
    {2'b10,1'b1,1'b0,1'b0,16'hC000,8'h00,8'hF7,4'h3,1'b0,8'h00}, // R5 page3
    {2'b01,1'b1,1'b0,1'b0,16'h0000,8'h00,8'h7F,4'hC,1'b0,8'h00}, // R5 exp1 page0
    {2'b11,1'b0,1'b1,1'b0,16'hFFFF,8'h55,8'hFF,4'h3,1'b0,8'h00}, // R3 deselected write
    {2'b10,1'b1,1'b0,1'b0,16'hFFFF,8'h00,8'hFF,4'h3,1'b1,8'h1B}, // R3 still E4
    {2'b10,1'b0,1'b0,1'b0,16'h0000,8'h00,8'hFF,4'hC,1'b0,8'h00}, // R6 no strobe
    {2'b11,1'b0,1'b1,1'b1,16'hFFFF,8'h27,8'hFF,4'h3,1'b0,8'h00}, // R8 broadcast
    {2'b10,1'b1,1'b0,1'b0,16'hFFFF,8'h00,8'hFF,4'h0,1'b1,8'hD8}, // R8 exp0
    {2'b01,1'b1,1'b0,1'b0,16'hFFFF,8'h00,8'hFF,4'h0,1'b1,8'hD8}, // R8 exp1
    {2'b01,1'b1,1'b0,1'b0,16'h4000,8'h00,8'hDF,4'h5,1'b0,8'h00}, // R7 flash both page1
    {2'b11,1'b1,1'b0,1'b0,16'hFFFF,8'h00,8'hFF,4'h0,1'b0,8'h00}  // R9 no select
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] s, input logic r, input logic w,
                        input logic b, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    slot_sel_n = s; rd = r; wr = w; bcast_wr = b; addr = a; wdata = d;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sub_sel_n", int'(sub_sel_n), 8'hFF);
    chk("R9 reset rdata_oe", int'(rdata_oe), 0);
    rst_n = 1;
    access(2'b10, 1, 0, 0, 16'hFFFF, 0);
    chk("R1 reset readback exp0", int'(rdata), 8'hFF);

    for (int v = 0; v < NV; v++) begin
      access(VEC[v][49:48], VEC[v][47], VEC[v][46], VEC[v][45], VEC[v][44:29], VEC[v][28:21]);
      chk($sformatf("R6 vec%0d sub_sel_n", v), int'(sub_sel_n), int'(VEC[v][20:13]));
      chk($sformatf("R7 vec%0d flash_page", v), int'(flash_page), int'(VEC[v][12:9]));
      chk($sformatf("R4 vec%0d rdata_oe", v), int'(rdata_oe), int'(VEC[v][8]));
      chk($sformatf("R9 vec%0d rdata", v), int'(rdata), int'(VEC[v][7:0]));
    end

    access(2'b10, 0, 1, 1, 16'hFFFF, 8'h93);
    access(2'b01, 1, 0, 0, 16'hFFFF, 0);
    chk("R8 broadcast with one select, exp1", int'(rdata), 8'h6C);
    access(2'b00, 1, 0, 0, 16'hFFFF, 0);
    chk("R4 both selected, lowest wins", int'(rdata), 8'h6C);

    access(2'b01, 0, 1, 0, 16'hFFFF, 8'hAA);
    access(2'b10, 1, 0, 0, 16'hFFFF, 0);
    chk("R2 exp0 untouched by exp1 write", int'(rdata), 8'h6C);
    access(2'b01, 1, 0, 0, 16'hC000, 0);
    chk("R5 exp1 page3 field 10", int'(sub_sel_n), 8'hBF);

    @(negedge clk); rst_n = 0;
    #(CLK_PERIOD/4); rst_n = 1;
    access(2'b01, 1, 0, 0, 16'hFFFF, 0);
    chk("R1 reset clears exp1", int'(rdata), 8'hFF);
    access(2'b10, 1, 0, 0, 16'hC000, 0);
    chk("R1 reset page3 sub0", int'(sub_sel_n), 8'hFE);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule